// File: doc/BRIEF.md
# Dual-Port Message Mailbox with Hardware Locks

This block lets two processors exchange short messages and share resources through two register ports, port A and port B. It holds four message slots. Each slot stores a data word and a command word, plus a pending flag that raises an interrupt toward the processor on the other side. Slots 0 and 1 carry messages toward side B, so their flags drive `irq_b`. Slots 2 and 3 carry messages toward side A, so their flags drive `irq_a`. A sender writes the data word first and then the command word. The command write sets the slot's flag. The receiver reads both words and then clears the flag by writing a one to its bit in the status register.

A bank of 32 single-bit locks lets software claim a shared resource without a read-modify-write race. A read of a free lock returns 0 and claims the lock in the same access. A read of a held lock returns 1 and leaves it unchanged. Writing 0 frees the lock. When both ports act on the same item in one cycle, port A has fixed priority.

The address map uses word addresses on an AW-bit bus:
- Slot i data word: address 2*i.
- Slot i command word: address 2*i+1.
- Status: address 8. Bit i is slot i's flag.
- Interrupt enable: address 9. Bit i enables slot i.
- Lock k: address 32+k. Bit 0 of the read data is the lock state before the access.

A read returns its value on `*_rdata` in the cycle after the access. The output is zero after any cycle without a read.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset, every data word, command word, flag and enable bit is zero, every lock is free, both interrupt outputs are low, and both read-data outputs are zero. A read-data output is zero in the cycle after any cycle in which its port did not read.
- R2: A word written to a slot's data (address 2*i) or command (address 2*i+1) register reads back unchanged from either port. The value appears on rdata in the cycle after the read access.
- R3: A write to slot i's command word sets status bit i (address 8) at that clock edge. A write to the data word alone leaves the flag unchanged.
- R4: Writing the status register clears each flag whose wdata bit is 1 and leaves flags whose wdata bit is 0 unchanged.
- R5: `irq_b` equals the OR of (flag AND enable) over slots 0 and 1, and `irq_a` equals the same OR over slots 2 and 3. The enable bits are at address 9, bit i for slot i, and each output follows the registered state directly.
- R6: If a command write sets a flag in the same cycle that a status write clears it, the flag ends set.
- R7: A read of lock k (address 32+k) returns 0 in bit 0 and claims the lock when it was free. It returns 1 and leaves the lock held when it was already held.
- R8: A write with wdata bit 0 = 0 to a lock frees it. A write with bit 0 = 1 has no effect.
- R9: If both ports write the same slot (either of its words) in one cycle, port A's write lands and port B's write is dropped entirely, including the flag set of a command write. Writes from the two ports to different slots both land.
- R10: If both ports read the same free lock in one cycle, port A gets 0 and holds the lock, and port B gets 1.
- R11: Reads of unmapped addresses return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_sel | input | 1 | Port A access this cycle |
| a_wr | input | 1 | Port A write (1) or read (0) |
| a_addr | input | AW | Port A word address |
| a_wdata | input | DW | Port A write data |
| a_rdata | output | DW | Port A read data, one cycle after the access |
| b_sel | input | 1 | Port B access this cycle |
| b_wr | input | 1 | Port B write (1) or read (0) |
| b_addr | input | AW | Port B word address |
| b_wdata | input | DW | Port B write data |
| b_rdata | output | DW | Port B read data, one cycle after the access |
| irq_a | output | 1 | Message pending toward side A |
| irq_b | output | 1 | Message pending toward side B |

## Verification
Two functions can meet on one slot flag in a single cycle: a sender's command write that sets the flag, and the receiver's write-one-to-clear. The bench drives both ports in the same clock cycle, one writing the command word of slot 0 and the other clearing bit 0 of the status register. It then reads status and expects the flag to be set. The same dual-drive technique sends two writes at one slot, and two reads at one free lock. In each case the bench judges the outcome against port A priority, and it also checks that port B's losing command write raises no flag.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    typedef enum logic [2:0] {
        HIT_NONE,
        HIT_DATA,
        HIT_CMD,
        HIT_STAT,
        HIT_EN,
        HIT_LOCK
    } hit_e;

endpackage

// File: rtl/mbx_port_dec.sv
module mbx_port_dec
    import mbx_pkg::*;
#(
    parameter int N_ELEM    = 4,
    parameter int N_LOCK    = 32,
    parameter int AW        = 6,
    parameter int LOCK_BASE = 32,
    parameter int EIW       = $clog2(N_ELEM)
) (
    input  logic              sel,
    input  logic              wr,
    input  logic [AW-1:0]     addr,
    input  logic              wd0,
    output hit_e              hit,
    output logic [EIW-1:0]    eidx,
    output logic [N_ELEM-1:0] data_wr,
    output logic [N_ELEM-1:0] cmd_wr,
    output logic              stat_wr,
    output logic              en_wr,
    output logic [N_LOCK-1:0] lock_rd,
    output logic [N_LOCK-1:0] lock_rel
);

    localparam logic [AW:0] ELEM_END = (AW+1)'(2 * N_ELEM);
    localparam logic [AW:0] STAT_A   = (AW+1)'(2 * N_ELEM);
    localparam logic [AW:0] EN_A     = (AW+1)'(2 * N_ELEM + 1);
    localparam logic [AW:0] LK_LO    = (AW+1)'(LOCK_BASE);
    localparam logic [AW:0] LK_HI    = (AW+1)'(LOCK_BASE + N_LOCK);

    logic [AW:0] ax;
    logic [AW:0] loff;

    always_comb begin
        ax       = {1'b0, addr};
        loff     = ax - LK_LO;
        eidx     = ax[EIW:1];
        hit      = HIT_NONE;
        data_wr  = '0;
        cmd_wr   = '0;
        lock_rd  = '0;
        lock_rel = '0;
        if (sel) begin
            if (ax < ELEM_END) begin
                hit = ax[0] ? HIT_CMD : HIT_DATA;
            end else if (ax == STAT_A) begin
                hit = HIT_STAT;
            end else if (ax == EN_A) begin
                hit = HIT_EN;
            end else if (ax >= LK_LO && ax < LK_HI) begin
                hit = HIT_LOCK;
            end
        end
        for (int i = 0; i < N_ELEM; i++) begin
            data_wr[i] = wr && (hit == HIT_DATA) && (eidx == EIW'(i));
            cmd_wr[i]  = wr && (hit == HIT_CMD)  && (eidx == EIW'(i));
        end
        stat_wr = wr && (hit == HIT_STAT);
        en_wr   = wr && (hit == HIT_EN);
        for (int k = 0; k < N_LOCK; k++) begin
            lock_rd[k]  = !wr && (hit == HIT_LOCK) && (loff == (AW+1)'(k));
            lock_rel[k] = wr && !wd0 && (hit == HIT_LOCK) && (loff == (AW+1)'(k));
        end
    end

endmodule

// File: rtl/mbx_elem_bank.sv
module mbx_elem_bank #(
    parameter int N_ELEM = 4,
    parameter int DW     = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [1:0][N_ELEM-1:0]       data_wr,
    input  logic [1:0][N_ELEM-1:0]       cmd_wr,
    input  logic [1:0]                   stat_wr,
    input  logic [1:0]                   en_wr,
    input  logic [1:0][DW-1:0]           wdata,
    output logic [N_ELEM-1:0][DW-1:0]    data_q,
    output logic [N_ELEM-1:0][DW-1:0]    cmd_q,
    output logic [N_ELEM-1:0]            flag_q,
    output logic [N_ELEM-1:0]            en_q
);

    typedef struct packed {
        logic [N_ELEM-1:0][DW-1:0] data;
        logic [N_ELEM-1:0][DW-1:0] cmd;
        logic [N_ELEM-1:0]         flag;
        logic [N_ELEM-1:0]         en;
    } elem_st_t;

    elem_st_t st_d, st_q;
    logic [N_ELEM-1:0] set_v;
    logic [N_ELEM-1:0] clr_v;
    logic [N_ELEM-1:0] a_owns;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N_ELEM; i++) begin
            a_owns[i] = data_wr[0][i] | cmd_wr[0][i];
            if (data_wr[0][i]) begin
                st_d.data[i] = wdata[0];
            end else if (data_wr[1][i] && !a_owns[i]) begin
                st_d.data[i] = wdata[1];
            end
            if (cmd_wr[0][i]) begin
                st_d.cmd[i] = wdata[0];
            end else if (cmd_wr[1][i] && !a_owns[i]) begin
                st_d.cmd[i] = wdata[1];
            end
            set_v[i] = cmd_wr[0][i] | (cmd_wr[1][i] & !a_owns[i]);
        end
        clr_v = (stat_wr[0] ? wdata[0][N_ELEM-1:0] : '0)
              | (stat_wr[1] ? wdata[1][N_ELEM-1:0] : '0);
        st_d.flag = set_v | (st_q.flag & ~clr_v);
        if (en_wr[0]) begin
            st_d.en = wdata[0][N_ELEM-1:0];
        end else if (en_wr[1]) begin
            st_d.en = wdata[1][N_ELEM-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_q = st_q.data;
    assign cmd_q  = st_q.cmd;
    assign flag_q = st_q.flag;
    assign en_q   = st_q.en;

    for (genvar gi = 0; gi < N_ELEM; gi++) begin : g_elem_chk
        // R3
        cmd_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set_v[gi] |=> flag_q[gi]);
        // R4
        w1c_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_v[gi] && !set_v[gi]) |=> !flag_q[gi]);
        // R9
        a_wins_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (data_wr[0][gi] && data_wr[1][gi]) |=> (data_q[gi] == $past(wdata[0])));
    end

endmodule

// File: rtl/mbx_lock_bank.sv
module mbx_lock_bank #(
    parameter int N_LOCK = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [1:0][N_LOCK-1:0] lock_rd,
    input  logic [1:0][N_LOCK-1:0] lock_rel,
    output logic [1:0]             rval
);

    typedef struct packed {
        logic [N_LOCK-1:0] held;
    } lock_st_t;

    lock_st_t st_d, st_q;
    logic [N_LOCK-1:0] acq_v;
    logic [N_LOCK-1:0] rel_v;

    always_comb begin
        acq_v     = (lock_rd[0] | lock_rd[1]) & ~st_q.held;
        rel_v     = lock_rel[0] | lock_rel[1];
        st_d.held = acq_v | (st_q.held & ~rel_v);
        rval[0]   = |(lock_rd[0] & st_q.held);
        rval[1]   = |(lock_rd[1] & (st_q.held | lock_rd[0]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar gk = 0; gk < N_LOCK; gk++) begin : g_lock_chk
        // R7
        free_read_claims_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (lock_rd[0][gk] && !st_q.held[gk]) |=> st_q.held[gk]);
        // R8
        release_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.held[gk] && (lock_rel[0][gk] || lock_rel[1][gk])) |=> !st_q.held[gk]);
        // R10
        race_b_loses_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (lock_rd[0][gk] && lock_rd[1][gk]) |-> rval[1]);
    end

endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
    import mbx_pkg::*;
#(
    parameter int N_ELEM    = 4,
    parameter int N_LOCK    = 32,
    parameter int DW        = 32,
    parameter int AW        = 6,
    parameter int LOCK_BASE = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          a_sel,
    input  logic          a_wr,
    input  logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_wdata,
    output logic [DW-1:0] a_rdata,
    input  logic          b_sel,
    input  logic          b_wr,
    input  logic [AW-1:0] b_addr,
    input  logic [DW-1:0] b_wdata,
    output logic [DW-1:0] b_rdata,
    output logic          irq_a,
    output logic          irq_b
);

    localparam int EIW    = $clog2(N_ELEM);
    localparam int N_PORT = 2;
    localparam int HALF   = N_ELEM / 2;

    typedef struct packed {
        logic [N_PORT-1:0][DW-1:0] rdata;
    } top_st_t;

    logic [N_PORT-1:0]             p_sel;
    logic [N_PORT-1:0]             p_wr;
    logic [N_PORT-1:0][AW-1:0]     p_addr;
    logic [N_PORT-1:0][DW-1:0]     p_wdata;
    hit_e                          p_hit [N_PORT];
    logic [N_PORT-1:0][EIW-1:0]    p_eidx;
    logic [N_PORT-1:0][N_ELEM-1:0] p_data_wr;
    logic [N_PORT-1:0][N_ELEM-1:0] p_cmd_wr;
    logic [N_PORT-1:0]             p_stat_wr;
    logic [N_PORT-1:0]             p_en_wr;
    logic [N_PORT-1:0][N_LOCK-1:0] p_lock_rd;
    logic [N_PORT-1:0][N_LOCK-1:0] p_lock_rel;
    logic [N_PORT-1:0]             lock_rval;

    logic [N_ELEM-1:0][DW-1:0]     data_q;
    logic [N_ELEM-1:0][DW-1:0]     cmd_q;
    logic [N_ELEM-1:0]             flag_q;
    logic [N_ELEM-1:0]             en_q;

    top_st_t st_d, st_q;

    assign p_sel   = {b_sel, a_sel};
    assign p_wr    = {b_wr, a_wr};
    assign p_addr  = {b_addr, a_addr};
    assign p_wdata = {b_wdata, a_wdata};

    for (genvar gp = 0; gp < N_PORT; gp++) begin : g_port
        mbx_port_dec #(
            .N_ELEM    (N_ELEM),
            .N_LOCK    (N_LOCK),
            .AW        (AW),
            .LOCK_BASE (LOCK_BASE),
            .EIW       (EIW)
        ) dec_i (
            .sel      (p_sel[gp]),
            .wr       (p_wr[gp]),
            .addr     (p_addr[gp]),
            .wd0      (p_wdata[gp][0]),
            .hit      (p_hit[gp]),
            .eidx     (p_eidx[gp]),
            .data_wr  (p_data_wr[gp]),
            .cmd_wr   (p_cmd_wr[gp]),
            .stat_wr  (p_stat_wr[gp]),
            .en_wr    (p_en_wr[gp]),
            .lock_rd  (p_lock_rd[gp]),
            .lock_rel (p_lock_rel[gp])
        );
    end

    mbx_elem_bank #(
        .N_ELEM (N_ELEM),
        .DW     (DW)
    ) elem_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .data_wr (p_data_wr),
        .cmd_wr  (p_cmd_wr),
        .stat_wr (p_stat_wr),
        .en_wr   (p_en_wr),
        .wdata   (p_wdata),
        .data_q  (data_q),
        .cmd_q   (cmd_q),
        .flag_q  (flag_q),
        .en_q    (en_q)
    );

    mbx_lock_bank #(
        .N_LOCK (N_LOCK)
    ) lock_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .lock_rd  (p_lock_rd),
        .lock_rel (p_lock_rel),
        .rval     (lock_rval)
    );

    always_comb begin
        st_d = st_q;
        for (int p = 0; p < N_PORT; p++) begin
            st_d.rdata[p] = '0;
            if (p_sel[p] && !p_wr[p]) begin
                case (p_hit[p])
                    HIT_DATA: st_d.rdata[p] = data_q[p_eidx[p]];
                    HIT_CMD:  st_d.rdata[p] = cmd_q[p_eidx[p]];
                    HIT_STAT: st_d.rdata[p] = DW'(flag_q);
                    HIT_EN:   st_d.rdata[p] = DW'(en_q);
                    HIT_LOCK: st_d.rdata[p] = DW'(lock_rval[p]);
                    default:  st_d.rdata[p] = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign a_rdata = st_q.rdata[0];
    assign b_rdata = st_q.rdata[1];
    assign irq_b   = |(flag_q[HALF-1:0] & en_q[HALF-1:0]);
    assign irq_a   = |(flag_q[N_ELEM-1:HALF] & en_q[N_ELEM-1:HALF]);

    // R5
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> (!irq_a && !irq_b));
    // R1
    idle_a_rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_sel && !a_wr) |=> (a_rdata == '0));
    // R1
    idle_b_rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(b_sel && !b_wr) |=> (b_rdata == '0));

endmodule

// File: tb/ipc_mailbox_tb_top.sv
module ipc_mailbox_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 6;
    localparam int DW = 32;
    localparam logic [AW-1:0] STAT = 6'd8;
    localparam logic [AW-1:0] EN   = 6'd9;
    localparam logic [AW-1:0] LK   = 6'd32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          a_sel = 1'b0, a_wr = 1'b0, b_sel = 1'b0, b_wr = 1'b0;
    logic [AW-1:0] a_addr = '0, b_addr = '0;
    logic [DW-1:0] a_wdata = '0, b_wdata = '0;
    logic [DW-1:0] a_rdata, b_rdata;
    logic          irq_a, irq_b;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ipc_mailbox dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_sel   (a_sel),
        .a_wr    (a_wr),
        .a_addr  (a_addr),
        .a_wdata (a_wdata),
        .a_rdata (a_rdata),
        .b_sel   (b_sel),
        .b_wr    (b_wr),
        .b_addr  (b_addr),
        .b_wdata (b_wdata),
        .b_rdata (b_rdata),
        .irq_a   (irq_a),
        .irq_b   (irq_b)
    );

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic acc(input bit port_b, input bit wr, input logic [AW-1:0] addr,
                       input logic [DW-1:0] wd, output logic [DW-1:0] rd);
        @(negedge clk);
        if (port_b) begin
            b_sel = 1'b1; b_wr = wr; b_addr = addr; b_wdata = wd;
        end else begin
            a_sel = 1'b1; a_wr = wr; a_addr = addr; a_wdata = wd;
        end
        @(negedge clk);
        rd = port_b ? b_rdata : a_rdata;
        a_sel = 1'b0; b_sel = 1'b0;
    endtask

    task automatic dual(input bit awr, input logic [AW-1:0] aad, input logic [DW-1:0] awd,
                        input bit bwr, input logic [AW-1:0] bad, input logic [DW-1:0] bwd,
                        output logic [DW-1:0] ard, output logic [DW-1:0] brd);
        @(negedge clk);
        a_sel = 1'b1; a_wr = awr; a_addr = aad; a_wdata = awd;
        b_sel = 1'b1; b_wr = bwr; b_addr = bad; b_wdata = bwd;
        @(negedge clk);
        ard = a_rdata; brd = b_rdata;
        a_sel = 1'b0; b_sel = 1'b0;
    endtask

    task automatic test_reset();
        logic [DW-1:0] r;
        chk("R1 irq_a", DW'(irq_a), 0);
        chk("R1 irq_b", DW'(irq_b), 0);
        chk("R1 a_rdata", a_rdata, 0);
        chk("R1 b_rdata", b_rdata, 0);
        acc(0, 0, STAT, 0, r); chk("R1 status", r, 0);
        acc(1, 0, EN, 0, r);   chk("R1 enable", r, 0);
        acc(0, 0, 6'd0, 0, r); chk("R1 data0", r, 0);
        acc(1, 0, 6'd7, 0, r); chk("R1 cmd3", r, 0);
        @(negedge clk);
        chk("R1 rdata idle", a_rdata, 0);
    endtask

    task automatic test_readback();
        logic [DW-1:0] r;
        acc(0, 1, 6'd0, 32'hDEADBEEF, r);
        acc(0, 0, 6'd0, 0, r);  chk("R2 data0 readback", r, 32'hDEADBEEF);
        acc(1, 0, STAT, 0, r);  chk("R3 data write sets no flag", r, 0);
        acc(0, 1, 6'd1, 32'h11, r);
        acc(1, 0, 6'd1, 0, r);  chk("R2 cmd0 readback", r, 32'h11);
        acc(1, 0, STAT, 0, r);  chk("R3 cmd write sets flag0", r, 32'h1);
    endtask

    task automatic test_irq();
        logic [DW-1:0] r;
        chk("R5 irq_b masked", DW'(irq_b), 0);
        acc(0, 1, EN, 32'h1, r);
        chk("R5 irq_b raised", DW'(irq_b), 1);
        chk("R5 irq_a quiet", DW'(irq_a), 0);
        acc(1, 1, STAT, 32'h0, r);
        acc(1, 0, STAT, 0, r);  chk("R4 zero bits keep flag", r, 32'h1);
        acc(1, 1, STAT, 32'h1, r);
        chk("R4 irq_b after clear", DW'(irq_b), 0);
        acc(1, 0, STAT, 0, r);  chk("R4 flag0 cleared", r, 0);
        acc(1, 1, 6'd4, 32'hCAFE, r);
        acc(1, 1, 6'd5, 32'h7, r);
        acc(0, 0, STAT, 0, r);  chk("R3 flag2 set by B", r, 32'h4);
        chk("R5 irq_a masked", DW'(irq_a), 0);
        acc(0, 1, EN, 32'h5, r);
        chk("R5 irq_a raised", DW'(irq_a), 1);
        chk("R5 irq_b no flag", DW'(irq_b), 0);
        acc(0, 1, STAT, 32'h4, r);
        chk("R5 irq_a after clear", DW'(irq_a), 0);
    endtask

    task automatic test_set_clear();
        logic [DW-1:0] ra, rb, r;
        dual(1, 6'd1, 32'h22, 1, STAT, 32'h1, ra, rb);
        acc(0, 0, STAT, 0, r);  chk("R6 set beats clear", r, 32'h1);
        chk("R6 irq_b on", DW'(irq_b), 1);
        acc(1, 1, STAT, 32'h1, r);
        acc(1, 0, STAT, 0, r);  chk("R6 cleared afterwards", r, 0);
    endtask

    task automatic test_collide();
        logic [DW-1:0] ra, rb, r;
        dual(1, 6'd2, 32'hAAAA, 1, 6'd2, 32'hBBBB, ra, rb);
        acc(1, 0, 6'd2, 0, r);  chk("R9 A wins data1", r, 32'hAAAA);
        dual(1, 6'd2, 32'h1, 1, 6'd3, 32'h2, ra, rb);
        acc(0, 0, 6'd3, 0, r);  chk("R9 B cmd1 dropped", r, 0);
        acc(0, 0, STAT, 0, r);  chk("R9 no flag from dropped cmd", r, 0);
        acc(0, 0, 6'd2, 0, r);  chk("R9 A data1 landed", r, 32'h1);
        dual(1, 6'd0, 32'h5, 1, 6'd6, 32'h6, ra, rb);
        acc(0, 0, 6'd0, 0, r);  chk("R9 A other slot lands", r, 32'h5);
        acc(1, 0, 6'd6, 0, r);  chk("R9 B other slot lands", r, 32'h6);
    endtask

    task automatic test_locks();
        logic [DW-1:0] r;
        acc(0, 0, LK + 6'd7, 0, r); chk("R7 free lock read 0", r, 0);
        acc(0, 0, LK + 6'd7, 0, r); chk("R7 held lock read 1", r, 1);
        acc(1, 0, LK + 6'd7, 0, r); chk("R7 held for B", r, 1);
        acc(1, 1, LK + 6'd7, 32'h1, r);
        acc(0, 0, LK + 6'd7, 0, r); chk("R8 write 1 ignored", r, 1);
        acc(1, 1, LK + 6'd7, 32'h0, r);
        acc(1, 0, LK + 6'd7, 0, r); chk("R8 write 0 releases", r, 0);
        acc(0, 0, LK + 6'd7, 0, r); chk("R7 B now holds", r, 1);
        acc(0, 0, LK + 6'd8, 0, r); chk("R7 neighbour lock free", r, 0);
    endtask

    task automatic test_lock_race();
        logic [DW-1:0] ra, rb, r;
        dual(0, LK + 6'd9, 0, 0, LK + 6'd9, 0, ra, rb);
        chk("R10 A gets free lock", ra, 0);
        chk("R10 B sees held", rb, 1);
        acc(1, 0, LK + 6'd9, 0, r); chk("R10 lock stays held", r, 1);
    endtask

    task automatic test_unmapped();
        logic [DW-1:0] r;
        acc(0, 1, 6'd20, 32'hFFFF_FFFF, r);
        acc(0, 0, 6'd20, 0, r);  chk("R11 unmapped read 0", r, 0);
        acc(1, 0, STAT, 0, r);   chk("R11 status untouched", r, 0);
        acc(1, 0, EN, 0, r);     chk("R11 enable untouched", r, 32'h5);
        acc(0, 0, 6'd0, 0, r);   chk("R11 data0 untouched", r, 32'h5);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_readback();
        test_irq();
        test_set_clear();
        test_collide();
        test_locks();
        test_lock_race();
        test_unmapped();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule